// File: doc/BRIEF.md
# Gated-clock parallel/serial-load shift register

An eight-stage register that converts a parallel byte into a serial bit stream, or passes a serial stream through a fixed eight-stage delay. On each rising clock edge a mode input picks one of two actions. In load mode the register captures the whole parallel word. In shift mode it moves every stage one place toward the output and takes a new bit into the first stage. Only the final stage drives the single output, so a loaded word leaves the block most significant bit first over eight clocks.

A clock-inhibit input freezes the contents. It works as a synchronous enable on the one system clock, and no gated clock is derived. An active-low clear empties every stage at once, without waiting for a clock edge, and it wins over inhibit, load and shift.

Top module: `pload_shreg`

## Requirements
- R1: While `clr_n` is 0, `q_out` reads 0. The clear takes effect as soon as `clr_n` falls, with no clock edge needed.
- R2: Clear has priority over everything else. Clock edges that arrive while `clr_n` is 0 change nothing. After release, every stage holds 0: with `ser`=1, the first seven enabled shifts leave `q_out` at 0 and the eighth makes it 1.
- R3: On a rising edge with `inhibit`=0 and `shift_nload`=0, the register captures `par_in`, and `q_out` then equals `par_in[7]`. Changes to `par_in` or `shift_nload` between edges do not alter `q_out`.
- R4: On a rising edge with `inhibit`=0 and `shift_nload`=1, each stage takes the value of the stage before it. The k-th shift after a load (k = 1 to 7) shows `par_in[7-k]` on `q_out`.
- R5: In shift mode, `ser` enters stage 0. A bit taken in at a given shift appears on `q_out` after eight enabled shifts.
- R6: On a rising edge with `inhibit`=1, the contents stay as they are, whether `shift_nload` asks for a load or a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| inhibit | input | 1 | 1 = hold contents on this edge |
| shift_nload | input | 1 | 1 = shift, 0 = parallel load |
| ser | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH (8) | Parallel word; bit 7 is the last stage |
| q_out | output | 1 | Last stage of the register |

## Verification
Several behaviours are checked on every cycle. Clear forces the output to 0. An inhibited edge leaves the output unchanged. A load places the top parallel bit on the output. A model fed only from the ports tracks the output through every load and shift. Other behaviours are visible only at points the bench picks: clear landing between clock edges in the middle of a shift, parallel inputs changing between edges with no effect, and the zeros that clear leaves behind surfacing as a stream of zeros before serial data reaches the output.

// File: rtl/pload_shreg.sv
module pload_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             inhibit,
  input  logic             shift_nload,
  input  logic             ser,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_out
);

  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] shifted;

  assign shifted = {stage[WIDTH-2:0], ser};

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      stage <= '0;
    else if (!inhibit)
      stage <= shift_nload ? shifted : par_in;
  end

  assign q_out = stage[WIDTH-1];

endmodule

// File: rtl/pload_shreg_chk.sv
module pload_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             inhibit,
  input logic             shift_nload,
  input logic             ser,
  input logic [WIDTH-1:0] par_in,
  input logic             q_out
);

  logic [WIDTH-1:0] hist;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      hist <= '0;
    else if (!inhibit) begin
      if (shift_nload)
        hist <= {hist[WIDTH-2:0], ser};
      else
        hist <= par_in;
    end
  end

  assert_clear_zero_R1: assert property (@(negedge clk) !clr_n |-> !q_out);

  assert_inhibit_hold_R6: assert property (@(posedge clk) disable iff (!clr_n)
    inhibit |=> $stable(q_out));

  assert_load_top_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (!inhibit && !shift_nload) |=> q_out == $past(par_in[WIDTH-1]));

  assert_stream_match_R5: assert property (@(negedge clk) disable iff (!clr_n)
    q_out == hist[WIDTH-1]);

endmodule

bind pload_shreg pload_shreg_chk #(.WIDTH(WIDTH)) chk (.*);

// File: tb/tb_pload_shreg.sv
module tb_pload_shreg;
  logic       clk = 0;
  logic       clr_n = 0;
  logic       inhibit = 0;
  logic       shift_nload = 1;
  logic       ser = 0;
  logic [7:0] par_in = '0;
  logic       q_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pload_shreg #(.WIDTH(8)) dut (.*);

  always #4 clk = ~clk;

  localparam logic [15:0] VEC [8] = '{
    16'hA5_3C, 16'h01_FF, 16'h80_00, 16'hFF_81,
    16'h5A_C3, 16'h00_7E, 16'h96_11, 16'h3B_E4
  };

  task automatic check(input logic exp, input string tag);
    total++;
    if (q_out !== exp) begin
      bad++;
      $display("FAIL %s: q_out=%b expected=%b at %0t", tag, q_out, exp, $time);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2;
    check(1'b0, "R1 reset state");
    edge_step();
    edge_step();
    clr_n = 1;
    edge_step();
    check(1'b0, "R1 after release");

    foreach (VEC[i]) begin
      logic [7:0] pb;
      logic [7:0] sb;
      pb = VEC[i][15:8];
      sb = VEC[i][7:0];
      shift_nload = 0;
      par_in = pb;
      edge_step();
      check(pb[7], "R3 load top bit");
      shift_nload = 1;
      par_in = ~pb;
      for (int k = 1; k <= 15; k++) begin
        ser = (k <= 8) ? sb[k-1] : 1'b0;
        edge_step();
        if (k <= 7)
          check(pb[7-k], "R4 shift order");
        else
          check(sb[k-8], "R5 serial after eight shifts");
      end
    end

    shift_nload = 0;
    par_in = 8'h80;
    edge_step();
    check(1'b1, "R3 load 0x80");
    par_in = 8'h00;
    #1;
    check(1'b1, "R3 no async load");

    inhibit = 1;
    for (int c = 0; c < 5; c++) begin
      shift_nload = c[0];
      ser = 1'b0;
      par_in = 8'h00;
      edge_step();
      check(1'b1, "R6 inhibit holds");
    end
    inhibit = 0;
    shift_nload = 1;
    edge_step();
    check(1'b0, "R6 resume shifts bit 6");

    shift_nload = 0;
    par_in = 8'hFF;
    edge_step();
    shift_nload = 1;
    ser = 1;
    edge_step();
    edge_step();
    check(1'b1, "R4 mid-shift value");
    #1;
    clr_n = 0;
    #1;
    check(1'b0, "R1 clear between edges");

    shift_nload = 0;
    par_in = 8'hFF;
    edge_step();
    edge_step();
    check(1'b0, "R2 clear beats load");
    #1;
    clr_n = 1;
    shift_nload = 1;
    ser = 1;
    for (int k = 1; k <= 8; k++) begin
      edge_step();
      check(k == 8, "R2 stages emptied by clear");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule